// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire, open-drain serial bus that fronts a byte-wide memory of 2^ADDR_W locations (2,048 by default). It runs on a fast system clock. It brings the bus clock and data lines into that clock domain through a two-stage synchroniser. On each line it watches for start conditions (data falls while the clock is high) and stop conditions (data rises while the clock is high). It also watches the rising and falling edges of the bus clock.

A transaction begins with an identity byte. The identity byte holds a four-bit device code, the page bits that form the top of the memory address, and a direction flag. A write sends a word byte, which sets the low eight address bits, followed by any number of data bytes. Each data byte is stored at once, so the slave never has to refuse an acknowledge while it finishes a write. Reads come in two forms:
- A current-address read starts at the internal counter.
- A selective read first loads the counter with a write that carries no data, then sends a repeated start and a read identity byte.

The counter steps once per byte and wraps from the top of the memory to zero. A write-protect input lets write bytes be acknowledged without storing them.

Top module: `twi_byte_mem`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `sda_oe` is low, so the slave releases the data line.
- R2: The slave acknowledges an identity byte (sent MSB first, bits [7:4] code, [3:1] page, [0] direction with 1 = read) only when bits [7:4] equal 4'b1010. A mismatched identity byte gets no acknowledge, and every later byte gets none either until the next start.
- R3: In a write, the byte that follows the identity byte is the word address. The counter becomes {page, word}. Each data byte that follows is acknowledged and stored at the counter.
- R4: The counter advances by one after each byte written or read, runs across page boundaries, and wraps from 2047 to 0.
- R5: A current-address read returns the byte at the counter, MSB first. The page bits of a read identity byte are ignored.
- R6: A selective read returns data starting at the address loaded by the write that carries no data, after a repeated start.
- R7: During reads the slave samples the master's acknowledge bit. If the master answers with a NACK, the slave stops driving and stays released until the next start.
- R8: While `wp` is high, write data bytes are still acknowledged, the counter still advances, and the memory is left unchanged.
- R9: A stop at any point returns the slave to idle without storing a partial byte, and a new command is accepted right after it. A start at any point restarts reception of the identity byte.
- R10: The slave only ever pulls the data line low (`sda_o` is 0). `sda_oe` never changes while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| wp | input | 1 | Write protect: blocks memory updates when high |
| sda_o | output | 1 | Data output value, always 0 (open drain) |
| sda_oe | output | 1 | High to pull the data line low |

## Verification
A counter that drifts or wraps wrongly shows up at the ports on the first byte read back after the fault. The bench uses bursts that cross a page boundary and the top of the memory, so this is caught within one byte time. A state machine that slips one bit shows up as a wrong or missing acknowledge on the ninth clock of the same byte, or as the slave holding the line low after a NACK or stop. A timing fault in the drive enable shows up as an enable change during a clock-high phase, which a monitor flags in the very cycle it happens. A failure of write protection only appears at the read back that follows, so protected writes are always read back at once.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ID,
    S_WORD,
    S_WDATA,
    S_ACK,
    S_RDATA,
    S_MACK
  } twi_state_t;
endpackage

// File: rtl/twi_line_sense.sv
module twi_line_sense (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_p    <= scl_sync[1];
      sda_p    <= sda_sync[1];
    end
  end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twi_byte_mem.sv
module twi_byte_mem #(
  parameter int         ADDR_W   = 11,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wp,
  output logic sda_o,
  output logic sda_oe
);
  import twi_pkg::*;
  localparam int PAGE_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  twi_state_t  state, nxt;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [7:0]  rd_q;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_W-1:0] page;
  logic        mack;
  logic        byte_in_done;
  logic        mem_we;

  twi_line_sense u_sense (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_in_done = scl_fall && (bitcnt == 4'd8);
  assign mem_we = !start_det && !stop_det && (state == S_WDATA) && byte_in_done && !wp;

  twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(addr), .wdata(shreg),
    .raddr(addr), .rdata(rd_q)
  );

  assign sda_o = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      nxt    <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      addr   <= '0;
      page   <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= S_ID;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        S_ID, S_WORD, S_WDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_in_done) begin
            bitcnt <= '0;
            if (state == S_ID) begin
              if (shreg[7:4] == DEV_CODE) begin
                sda_oe <= 1'b1;
                state  <= S_ACK;
                if (shreg[0]) nxt <= S_RDATA;
                else begin
                  nxt  <= S_WORD;
                  page <= shreg[PAGE_W:1];
                end
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_WORD) begin
              sda_oe <= 1'b1;
              addr   <= {page, shreg};
              state  <= S_ACK;
              nxt    <= S_WDATA;
            end else begin
              sda_oe <= 1'b1;
              addr   <= addr + 1'b1;
              state  <= S_ACK;
              nxt    <= S_WDATA;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (nxt == S_RDATA) begin
              shreg  <= rd_q;
              sda_oe <= ~rd_q[7];
              addr   <= addr + 1'b1;
              state  <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= nxt;
            end
          end
        end
        S_RDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= S_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              shreg  <= rd_q;
              sda_oe <= ~rd_q[7];
              addr   <= addr + 1'b1;
              state  <= S_RDATA;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/twi_byte_mem_chk.sv
module twi_byte_mem_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              start_det,
  input logic              stop_det,
  input logic              scl_fall,
  input logic              sda_oe,
  input logic              mem_we,
  input logic [ADDR_W-1:0] addr,
  input twi_pkg::twi_state_t state
);
  // R1: idle slave never pulls the line
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state == twi_pkg::S_IDLE) |-> !sda_oe);

  // R9: a stop releases the line in the next cycle
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R10: drive enable only moves after a clock fall, start or stop
  a_r10_oe_timing: assert property (@(posedge clk) disable iff (rst)
    (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe));

  // R4: a stored byte advances the counter by one, modulo the memory size
  a_r4_write_advance: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (addr == $past(addr) + 1'b1));

  // R4: the counter is quiet between bus clock falls
  a_r4_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    !scl_fall |=> $stable(addr));
endmodule

bind twi_byte_mem twi_byte_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
  .scl_fall(scl_fall), .sda_oe(sda_oe), .mem_we(mem_we), .addr(addr),
  .state(state)
);

// File: tb/tb_twi_byte_mem.sv
module tb_twi_byte_mem;
  localparam int H = 20;
  localparam int MEMSZ = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_o, sda_oe;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  int r10_viol = 0;
  logic [7:0] model [0:MEMSZ-1];

  assign sda_bus = sda_oe ? sda_o : m_sda;

  always #5 clk = ~clk;

  twi_byte_mem dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .wp(wp),
    .sda_o(sda_o), .sda_oe(sda_oe)
  );

  // R10 monitor: enable must hold while the bus clock stays high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(posedge clk) begin
    #1;
    if (!rst && scl && prev_scl && (sda_oe !== prev_oe)) r10_viol++;
    if (sda_o !== 1'b0) r10_viol++;
    prev_scl = scl;
    prev_oe  = sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(H); scl = 1'b1; w(H); m_sda = 1'b0; w(H); scl = 1'b0; w(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(H); scl = 1'b1; w(H); m_sda = 1'b1; w(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; w(H); scl = 1'b1; w(H); scl = 1'b0;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; w(H); scl = 1'b1; w(H/2);
    ack = ~sda_bus;
    w(H/2); scl = 1'b0;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl = 1'b1; w(H/2); b[i] = sda_bus; w(H/2); scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    w(H); scl = 1'b1; w(H); scl = 1'b0;
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] id_byte(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic write_burst(input string req, input logic [10:0] a, input int n, input int seed);
    logic ack;
    bus_start();
    wr_byte(id_byte(a, 1'b0), ack); chk({req, " id ack"}, ack, 1);
    wr_byte(a[7:0], ack);           chk({req, " word ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [10:0] ad;
      logic [7:0]  v;
      ad = a + 11'(k);
      v  = 8'((ad * 7 + seed) & 8'hff);
      wr_byte(v, ack);
      chk({req, " data ack"}, ack, 1);
      if (!wp) model[ad] = v;
    end
    bus_stop();
  endtask

  task automatic sel_read(input string req, input logic [10:0] a, input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    wr_byte(id_byte(a, 1'b0), ack); chk({req, " id ack"}, ack, 1);
    wr_byte(a[7:0], ack);           chk({req, " word ack"}, ack, 1);
    bus_start();
    wr_byte(8'hA1, ack);            chk({req, " rd id ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, b);
      chk({req, " data"}, b, model[11'(a + 11'(k))]);
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    logic       seen;
    w(5);
    chk("R1 reset oe", sda_oe, 0);
    rst = 1'b0;
    w(10);
    chk("R1 idle oe", sda_oe, 0);

    // R2: sweep every device code, write direction
    for (int c = 0; c < 16; c++) begin
      bus_start();
      wr_byte({4'(c), 3'b000, 1'b0}, ack);
      chk("R2 code ack", ack, (c == 10) ? 1 : 0);
      if (c != 10) begin
        wr_byte(8'h00, ack);
        chk("R2 ignored after mismatch", ack, 0);
      end
      bus_stop();
    end

    // R3/R4: burst across the page 3 -> 4 boundary
    write_burst("R3", 11'h3F8, 24, 3);
    sel_read("R6 R4 page cross", 11'h3F8, 16);

    // R7: after the NACK the slave stays released over further clocks
    seen = 1'b0;
    bus_start();
    wr_byte(8'hA1, ack);
    rd_byte(1'b0, b);
    for (int i = 0; i < 18; i++) begin
      w(H); scl = 1'b1; w(H/2);
      if (sda_bus == 1'b0) seen = 1'b1;
      w(H/2); scl = 1'b0;
    end
    chk("R7 released after nack", seen, 0);
    bus_stop();

    // R5: current read, counter now 0x3F8+16 then one more read -> 0x409
    bus_start();
    wr_byte({4'b1010, 3'b101, 1'b1}, ack);
    chk("R5 id ack", ack, 1);
    rd_byte(1'b1, b); chk("R5 current data", b, model[11'h409]);
    rd_byte(1'b0, b); chk("R5 next data", b, model[11'h40A]);
    bus_stop();

    // R4: wrap at the top of memory
    write_burst("R4 wrap", 11'h7FC, 8, 11);
    sel_read("R4 wrap read", 11'h7FE, 4);

    // R8: protected writes acked but not stored
    wp = 1'b1;
    write_burst("R8", 11'h7FC, 2, 99);
    wp = 1'b0;
    sel_read("R8 unchanged", 11'h7FC, 2);

    // R9: stop mid byte leaves memory untouched, next command accepted
    write_burst("R9 prep", 11'h010, 1, 5);
    bus_start();
    wr_byte(8'hA0, ack);
    wr_byte(8'h10, ack);
    send_bits(8'hFF, 3);
    bus_stop();
    sel_read("R9 stop partial", 11'h010, 1);

    // R9: start mid byte restarts identity reception
    write_burst("R9 prep2", 11'h020, 1, 8);
    bus_start();
    wr_byte(8'hA0, ack);
    wr_byte(8'h20, ack);
    send_bits(8'h00, 5);
    m_sda = 1'b1; w(H);
    bus_start();
    wr_byte(8'hA1, ack);
    chk("R9 restart id ack", ack, 1);
    rd_byte(1'b0, b);
    chk("R9 restart data", b, model[11'h020]);
    bus_stop();
    w(10);
    chk("R1 idle after stop", sda_oe, 0);

    chk("R10 oe steady while scl high", r10_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule